// File: doc/BRIEF.md
# Reset and Boot-Mode Sequencer

This block decides when a small processor core may leave reset and how its program memory is filled before the first instruction fetch. A cold power-up is signalled on `por_n`. After it, the core is held for a programmable interval so that the clock multiplier can lock. Later warm resets arrive on `rst_req_n` and skip that interval, because the clock is already running. While `rst_req_n` is low, the block asserts the core's reset actions and samples three strap inputs. The straps choose the start-up method and the memory configuration.

After release the sequencer waits for any pending bus request to be withdrawn. It then performs one of three start-ups:
- Fill the first `BOOT_WORDS` program words from byte memory, one 24-bit word per three bytes.
- Start at once from external memory.
- Wait until a host has written internal program location zero.

It then pulses `core_go`, which starts fetching at program address zero. The address is external when `fetch_ext` is high and internal otherwise.

Top module: `boot_seq_top`

## Requirements
- R1: Within one clock of `rst_req_n` being sampled low, `sp_clear`, `irq_mask` and `stat_clear` are 1 and `core_hold` is 1. All three reset actions are 0 once the core runs.
- R2: After `por_n` is released, `core_hold` stays 1 and `bm_req` stays 0 for at least `LOCK_CYCLES` clocks, whatever `rst_req_n` does.
- R3: On any later warm reset there is no lock wait. With external start selected, `core_go` is 1 in the cycle after the first clock edge that samples `rst_req_n` high.
- R4: The straps are captured only on clock edges where `rst_req_n` is low, so the last value seen before release is kept. Strap changes while `rst_req_n` is high have no effect.
- R5: `host_mem_mode` equals the captured `mode_c`: 0 selects full-memory mode and 1 selects host-memory mode.
- R6: If `bus_req` is 1 when reset releases, nothing starts (`bm_req`=0, `core_hold`=1) until `bus_req` returns to 0. The strap choice is then made.
- R7: With `mode_a`=0 and `mode_b`=0, bytes are read from `bm_addr` 0, 1, 2, … up to 3·`BOOT_WORDS`−1. Each group of three consecutive bytes is written as one word, with the first byte in bits 23:16, the second in bits 15:8 and the third in bits 7:0. The words go to `pm_addr` 0 through `BOOT_WORDS`−1 in order.
- R8: During a byte-memory boot, `core_hold` stays 1 through every program write. `core_go` comes only after the last word has been written.
- R9: With `mode_a`=0 and `mode_b`=1, no byte is requested. `core_go` pulses with `fetch_ext`=1.
- R10: With `mode_a`=1, the core stays held until `host_we` is 1 with `host_addr`=0. Host writes to other addresses do not release it. `core_go` follows one cycle later with `fetch_ext`=0.
- R11: `core_go` is a single-cycle pulse. `core_hold` is 0 from that cycle until the next reset.
- R12: A byte transfer happens only in a cycle where both `bm_req` and `bm_valid` are 1. Stall cycles neither advance the address nor lose or duplicate a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Cold power-on reset, asynchronous, active low |
| rst_req_n | input | 1 | Warm reset request, synchronous, active low |
| mode_a | input | 1 | Strap: 1 selects host loading |
| mode_b | input | 1 | Strap: 1 disables automatic boot |
| mode_c | input | 1 | Strap: 1 selects host-memory mode |
| bus_req | input | 1 | External bus request pending |
| bm_valid | input | 1 | Byte memory data valid |
| bm_data | input | 8 | Byte memory read data |
| host_we | input | 1 | Host write strobe into internal memory |
| host_addr | input | PM_AW | Host write address |
| bm_req | output | 1 | Byte read request |
| bm_addr | output | BM_AW | Byte read address |
| pm_we | output | 1 | Program memory write strobe |
| pm_addr | output | PM_AW | Program memory write address |
| pm_wdata | output | 24 | Program memory write word |
| core_hold | output | 1 | Core held (no fetch) |
| core_go | output | 1 | One-cycle start pulse, fetch from address 0 |
| fetch_ext | output | 1 | First fetch from external memory |
| sp_clear | output | 1 | Empty all stack pointers |
| irq_mask | output | 1 | Mask all interrupts |
| stat_clear | output | 1 | Clear mode/status register |
| host_mem_mode | output | 1 | Captured memory mode |

## Verification
The bench builds the block with `LOCK_CYCLES`=40, `BOOT_WORDS`=4, `BM_AW`=8 and `PM_AW`=10. With these values the cold lock wait, a complete byte-memory boot with and without stall cycles, and every warm-reset start-up path all fit within a few hundred cycles. The short boot length lets the bench check every single word write against an expected item. The lock length is still large enough to release `rst_req_n` well before the lock ends, so the test shows that the lock wait alone holds the core.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    ST_RESET    = 3'd0,
    ST_BUSWAIT  = 3'd1,
    ST_DMA      = 3'd2,
    ST_HOSTWAIT = 3'd3,
    ST_RUN      = 3'd4
  } seq_state_e;

  typedef struct packed {
    logic host_mem;   // memory configuration strap
    logic no_boot;    // skip automatic boot
    logic host_load;  // host fills internal memory
  } strap_t;

  function automatic seq_state_e pick_boot(input strap_t s);
    if (s.host_load)    return ST_HOSTWAIT;
    else if (s.no_boot) return ST_RUN;
    else                return ST_DMA;
  endfunction

endpackage

// File: rtl/boot_lock_timer.sv
module boot_lock_timer #(
  parameter int LOCK_CYCLES = 2000
) (
  input  logic clk,
  input  logic por_n,
  output logic busy
);
  localparam int CW = $clog2(LOCK_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(LOCK_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          flag_q, flag_d;

  always_comb begin
    cnt_d  = cnt_q;
    flag_d = flag_q;
    if (flag_q) begin
      if (cnt_q == LAST) flag_d = 1'b0;
      else               cnt_d  = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      flag_q <= flag_d;
    end
  end

  assign busy = flag_q;

  // R2
  cold_once_chk: assert property (@(posedge clk) disable iff (!por_n)
    !flag_q |=> !flag_q);

endmodule

// File: rtl/boot_strap_latch.sv
module boot_strap_latch
  import boot_seq_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   capture,
  input  logic   mode_a,
  input  logic   mode_b,
  input  logic   mode_c,
  output strap_t strap_q
);
  strap_t strap_d;

  always_comb begin
    strap_d = strap_q;
    if (capture) begin
      strap_d.host_load = mode_a;
      strap_d.no_boot   = mode_b;
      strap_d.host_mem  = mode_c;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) strap_q <= '0;
    else        strap_q <= strap_d;
  end

  // R4
  strap_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    !capture |=> $stable(strap_q));

endmodule

// File: rtl/boot_byte_loader.sv
module boot_byte_loader #(
  parameter int BOOT_WORDS = 32,
  parameter int BM_AW      = 16,
  parameter int PM_AW      = 14
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             active,
  input  logic             bm_valid,
  input  logic [7:0]       bm_data,
  output logic             bm_req,
  output logic [BM_AW-1:0] bm_addr,
  output logic             pm_we,
  output logic [PM_AW-1:0] pm_addr,
  output logic [23:0]      pm_wdata,
  output logic             done
);
  localparam int WCW = $clog2(BOOT_WORDS + 1);
  localparam logic [WCW-1:0] WORDS = WCW'(BOOT_WORDS);

  logic [WCW-1:0]   word_q, word_d, widx_q, widx_d;
  logic [1:0]       sub_q, sub_d;
  logic [BM_AW-1:0] addr_q, addr_d;
  logic [7:0]       hi_q, hi_d, mid_q, mid_d;
  logic [23:0]      wdat_q, wdat_d;
  logic             we_q, we_d;
  logic             take;

  assign done   = (word_q == WORDS);
  assign bm_req = active && !done;
  assign take   = bm_req && bm_valid;

  always_comb begin
    word_d = word_q;
    widx_d = widx_q;
    sub_d  = sub_q;
    addr_d = addr_q;
    hi_d   = hi_q;
    mid_d  = mid_q;
    wdat_d = wdat_q;
    we_d   = 1'b0;
    if (!active) begin
      word_d = '0;
      sub_d  = '0;
      addr_d = '0;
    end else if (take) begin
      addr_d = addr_q + 1'b1;
      case (sub_q)
        2'd0: begin hi_d  = bm_data; sub_d = 2'd1; end
        2'd1: begin mid_d = bm_data; sub_d = 2'd2; end
        default: begin
          we_d   = 1'b1;
          wdat_d = {hi_q, mid_q, bm_data};
          widx_d = word_q;
          word_d = word_q + 1'b1;
          sub_d  = 2'd0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      word_q <= '0;
      widx_q <= '0;
      sub_q  <= '0;
      addr_q <= '0;
      hi_q   <= '0;
      mid_q  <= '0;
      wdat_q <= '0;
      we_q   <= 1'b0;
    end else begin
      word_q <= word_d;
      widx_q <= widx_d;
      sub_q  <= sub_d;
      addr_q <= addr_d;
      hi_q   <= hi_d;
      mid_q  <= mid_d;
      wdat_q <= wdat_d;
      we_q   <= we_d;
    end
  end

  assign bm_addr  = addr_q;
  assign pm_we    = we_q;
  assign pm_addr  = PM_AW'(widx_q);
  assign pm_wdata = wdat_q;

  // R7
  pm_idx_chk: assert property (@(posedge clk) disable iff (!por_n)
    pm_we |-> (widx_q < WORDS));

  // R12
  stall_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bm_req && !bm_valid) |=> ($stable(addr_q) || !active));

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int LOCK_CYCLES = 2000,
  parameter int BOOT_WORDS  = 32,
  parameter int BM_AW       = 16,
  parameter int PM_AW       = 14
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             rst_req_n,
  input  logic             mode_a,
  input  logic             mode_b,
  input  logic             mode_c,
  input  logic             bus_req,
  input  logic             bm_valid,
  input  logic [7:0]       bm_data,
  input  logic             host_we,
  input  logic [PM_AW-1:0] host_addr,
  output logic             bm_req,
  output logic [BM_AW-1:0] bm_addr,
  output logic             pm_we,
  output logic [PM_AW-1:0] pm_addr,
  output logic [23:0]      pm_wdata,
  output logic             core_hold,
  output logic             core_go,
  output logic             fetch_ext,
  output logic             sp_clear,
  output logic             irq_mask,
  output logic             stat_clear,
  output logic             host_mem_mode
);
  seq_state_e state_q, state_d;
  strap_t     strap_q;
  logic       lock_busy, load_done, go_q, go_d;

  boot_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk(clk), .por_n(por_n), .busy(lock_busy)
  );

  boot_strap_latch u_strap (
    .clk(clk), .por_n(por_n), .capture(!rst_req_n),
    .mode_a(mode_a), .mode_b(mode_b), .mode_c(mode_c), .strap_q(strap_q)
  );

  boot_byte_loader #(.BOOT_WORDS(BOOT_WORDS), .BM_AW(BM_AW), .PM_AW(PM_AW)) u_load (
    .clk(clk), .por_n(por_n), .active(state_q == ST_DMA),
    .bm_valid(bm_valid), .bm_data(bm_data), .bm_req(bm_req), .bm_addr(bm_addr),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata), .done(load_done)
  );

  always_comb begin
    state_d = state_q;
    if (!rst_req_n) begin
      state_d = ST_RESET;
    end else begin
      case (state_q)
        ST_RESET:    if (!lock_busy) state_d = bus_req ? ST_BUSWAIT : pick_boot(strap_q);
        ST_BUSWAIT:  if (!bus_req)   state_d = pick_boot(strap_q);
        ST_DMA:      if (load_done)  state_d = ST_RUN;
        ST_HOSTWAIT: if (host_we && host_addr == '0) state_d = ST_RUN;
        ST_RUN:      state_d = ST_RUN;
        default:     state_d = ST_RESET;
      endcase
    end
    go_d = (state_q != ST_RUN) && (state_d == ST_RUN);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      state_q <= ST_RESET;
      go_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      go_q    <= go_d;
    end
  end

  assign core_hold     = (state_q != ST_RUN);
  assign core_go       = go_q;
  assign fetch_ext     = (state_q == ST_RUN) && strap_q.no_boot && !strap_q.host_load;
  assign sp_clear      = (state_q == ST_RESET);
  assign irq_mask      = (state_q == ST_RESET);
  assign stat_clear    = (state_q == ST_RESET);
  assign host_mem_mode = strap_q.host_mem;

  // R1
  rst_act_chk: assert property (@(posedge clk) disable iff (!por_n)
    !rst_req_n |=> (sp_clear && irq_mask && stat_clear && core_hold));

  // R2
  lock_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock_busy |-> (core_hold && !bm_req));

  // R6
  bus_wait_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_BUSWAIT && bus_req && rst_req_n) |=> (state_q == ST_BUSWAIT));

  // R8
  dma_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (bm_req || pm_we) |-> core_hold);

  // R10
  host_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    (state_q == ST_HOSTWAIT && rst_req_n && !(host_we && host_addr == '0)) |=> core_hold);

  // R11
  go_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_go |=> !core_go);

endmodule

// File: tb/sim_boot_seq_top.sv
`timescale 1ns/1ps
module sim_boot_seq_top;
  localparam int LOCK = 40;
  localparam int BW   = 4;
  localparam int BMA  = 8;
  localparam int PMA  = 10;

  logic clk = 1'b0;
  logic por_n, rst_req_n, mode_a, mode_b, mode_c, bus_req, host_we, bm_valid;
  logic [7:0] bm_data;
  logic [PMA-1:0] host_addr;
  logic bm_req, pm_we, core_hold, core_go, fetch_ext, sp_clear, irq_mask, stat_clear, host_mem_mode;
  logic [BMA-1:0] bm_addr;
  logic [PMA-1:0] pm_addr;
  logic [23:0] pm_wdata;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic stall_en = 1'b0;
  logic [7:0] seed = 8'd0;
  logic [PMA+23:0] exp_q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] byte_of(input int a, input logic [7:0] s);
    return 8'(a * 37 + 11) ^ s;
  endfunction

  assign bm_valid = bm_req && !(stall_en && (cyc % 4 == 1));
  assign bm_data  = byte_of(int'(bm_addr), seed);

  boot_seq_top #(.LOCK_CYCLES(LOCK), .BOOT_WORDS(BW), .BM_AW(BMA), .PM_AW(PMA)) u0 (
    .clk(clk), .por_n(por_n), .rst_req_n(rst_req_n), .mode_a(mode_a), .mode_b(mode_b),
    .mode_c(mode_c), .bus_req(bus_req), .bm_valid(bm_valid), .bm_data(bm_data),
    .host_we(host_we), .host_addr(host_addr), .bm_req(bm_req), .bm_addr(bm_addr),
    .pm_we(pm_we), .pm_addr(pm_addr), .pm_wdata(pm_wdata), .core_hold(core_hold),
    .core_go(core_go), .fetch_ext(fetch_ext), .sp_clear(sp_clear), .irq_mask(irq_mask),
    .stat_clear(stat_clear), .host_mem_mode(host_mem_mode)
  );

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver side of the scoreboard: expected program writes (R7)
  task automatic push_boot(input logic [7:0] s);
    for (int i = 0; i < BW; i++)
      exp_q.push_back({PMA'(i), byte_of(3*i, s), byte_of(3*i+1, s), byte_of(3*i+2, s)});
  endtask

  // monitor side: every write is compared in order (R7, R8, R12)
  always @(negedge clk) begin
    if (por_n && pm_we) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7 unexpected write", longint'({pm_addr, pm_wdata}), 0);
      end else begin
        logic [PMA+23:0] e;
        e = exp_q.pop_front();
        chk({pm_addr, pm_wdata} == e, "R7/R12 word", longint'({pm_addr, pm_wdata}), longint'(e));
        chk(core_hold == 1'b1, "R8 hold during write", core_hold, 1);
      end
    end
  end

  task automatic wait_go(input string req);
    int n = 0;
    while (!core_go && n < 2000) begin @(negedge clk); n++; end
    chk(core_go == 1'b1, req, core_go, 1);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=0 expected=1");
    summary();
    $finish;
  end

  initial begin
    int bad;
    por_n = 0; rst_req_n = 0; mode_a = 0; mode_b = 0; mode_c = 1;
    bus_req = 0; host_we = 0; host_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sp_clear && irq_mask && stat_clear && core_hold, "R1 reset actions",
        {sp_clear, irq_mask, stat_clear, core_hold}, 4'hf);
    chk(!core_go && !bm_req && !pm_we, "R1 quiet outputs", {core_go, bm_req, pm_we}, 0);

    // cold power-up, byte boot with stalls
    seed = 8'h5a; stall_en = 1'b1; push_boot(seed);
    por_n = 1;
    bad = 0;
    for (int i = 0; i < LOCK; i++) begin
      @(negedge clk);
      if (i == 4) rst_req_n = 1;
      if (bm_req || !core_hold) bad++;
    end
    chk(bad == 0, "R2 lock interval hold", bad, 0);
    wait_go("R8 go after byte boot");
    chk(exp_q.size() == 0, "R8 all words before go", exp_q.size(), 0);
    chk(fetch_ext == 1'b0, "R11 internal fetch", fetch_ext, 0);
    chk(host_mem_mode == 1'b1, "R5 host memory mode", host_mem_mode, 1);
    chk(!sp_clear && !irq_mask && !stat_clear, "R1 actions off when running",
        {sp_clear, irq_mask, stat_clear}, 0);
    @(negedge clk);
    chk(core_go == 1'b0 && core_hold == 1'b0, "R11 single pulse", {core_go, core_hold}, 0);

    // warm reset, external start
    stall_en = 1'b0;
    rst_req_n = 0; mode_a = 0; mode_b = 1; mode_c = 0;
    @(negedge clk);
    chk(sp_clear && irq_mask && stat_clear && core_hold, "R1 warm reset actions",
        {sp_clear, irq_mask, stat_clear, core_hold}, 4'hf);
    @(negedge clk);
    rst_req_n = 1;
    @(negedge clk);
    chk(core_go == 1'b1, "R3 no lock wait on warm reset", core_go, 1);
    chk(fetch_ext == 1'b1 && core_hold == 1'b0, "R9 external start", {fetch_ext, core_hold}, 2'b10);
    chk(bm_req == 1'b0, "R9 no byte request", bm_req, 0);
    chk(host_mem_mode == 1'b0, "R5 full memory mode", host_mem_mode, 0);

    // straps ignored while released
    mode_c = 1; mode_a = 1;
    repeat (3) @(negedge clk);
    chk(host_mem_mode == 1'b0 && fetch_ext == 1'b1, "R4 straps ignored while running",
        {host_mem_mode, fetch_ext}, 2'b01);

    // host load
    rst_req_n = 0; mode_a = 1; mode_b = 0; mode_c = 0;
    repeat (2) @(negedge clk);
    mode_a = 0; mode_c = 1; // R4: changes on the release edge are not taken
    rst_req_n = 1;
    repeat (3) @(negedge clk);
    chk(core_hold == 1'b1 && bm_req == 1'b0, "R10 held waiting for host", {core_hold, bm_req}, 2'b10);
    chk(host_mem_mode == 1'b0, "R4 last low-phase strap kept", host_mem_mode, 0);
    host_we = 1; host_addr = PMA'(3);
    @(negedge clk);
    host_we = 0;
    @(negedge clk);
    chk(core_hold == 1'b1 && core_go == 1'b0, "R10 other address no release", {core_hold, core_go}, 2'b10);
    host_we = 1; host_addr = '0;
    @(negedge clk);
    host_we = 0;
    chk(core_go == 1'b1 && fetch_ext == 1'b0, "R10 release on location zero", {core_go, fetch_ext}, 2'b10);

    // bus request pending at release, then byte boot without stalls
    rst_req_n = 0; mode_a = 0; mode_b = 0; mode_c = 0; bus_req = 1;
    repeat (2) @(negedge clk);
    rst_req_n = 1;
    bad = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (bm_req || !core_hold) bad++;
    end
    chk(bad == 0, "R6 wait while bus requested", bad, 0);
    seed = 8'hc3; push_boot(seed);
    bus_req = 0;
    wait_go("R6 boot after bus released");
    chk(exp_q.size() == 0, "R7 all words written", exp_q.size(), 0);
    chk(core_hold == 1'b0, "R11 running", core_hold, 0);

    summary();
    $finish;
  end
endmodule